// File: doc/BRIEF.md
# 1553 Remote Terminal Command Decoder

This block sits behind the word decoder of a dual-redundant serial bus remote terminal. Each time a validated 16-bit command word arrives, it decides whether the terminal must act on it. It compares the command's terminal address with a strapped 5-bit address. That strapped address is guarded by an odd parity bit. An all-ones address is recognised as a broadcast when the broadcast enable is high. A command is accepted if it matches the terminal's own address with good strap parity, or if it is a recognised broadcast.

On acceptance the block captures the transmit/receive bit, the subaddress, the word count field and two flags: broadcast, and mode command. A mode command is one whose subaddress is all zeros or all ones. The block raises an in-command flag until the host signals the end of the service.

A 5-bit count output serves the host's address lines. While in-command is low, or while a mode command is held, it shows the captured word count field. During a data command it shows a live counter instead. That counter starts at zero on acceptance and steps once for every data word transferred.

Top module: `rt_cmd_decoder`

## Requirements
- R1: A command whose address field (bits 15:11) equals the strapped address, with good strap parity, gives a one-cycle `cmd_accept` pulse in the cycle after `cmd_valid`. `in_cmd` is high from that cycle on and `bcast` is low.
- R2: With `bcast_en` high, a command to address 31 is accepted with `bcast` high, whatever the strapped address.
- R3: With `bcast_en` low, a command to address 31 is accepted only when the strapped address is 31 with good parity, and then with `bcast` low.
- R4: The strap parity is odd: `addr_err_n` is low exactly when `rt_addr` and `rt_addr_par` together hold an even number of ones.
- R5: While `addr_err_n` is low, commands to the terminal's own address are ignored. No accept pulse follows, `in_cmd` stays low, and the captured outputs keep their values. Broadcasts are still accepted when `bcast_en` is high.
- R6: A command to any other address that is not a recognised broadcast is ignored in the same way.
- R7: On acceptance, `tr_bit` takes bit 10 and `subaddr` takes bits 9:5 of the command. Both hold until the next accepted command.
- R8: `mode_cmd` is set on acceptance when the subaddress is 0 or 31, and is cleared for any other subaddress.
- R9: While `in_cmd` is low or `mode_cmd` is high, `count_out` equals the captured word count field (bits 4:0). `word_done` pulses do not change it.
- R10: During a data command, `count_out` shows the live word counter. It reads 0 in the cycle after acceptance and rises by one for every `word_done` pulse.
- R11: `cmd_end` clears `in_cmd` at the next edge. If an accepted command arrives in the same cycle, the command wins and `in_cmd` stays high.
- R12: A `word_done` pulse in the same cycle as an accepted command leaves the live counter at 0.
- R13: After reset, `in_cmd`, `cmd_accept`, `bcast`, `mode_cmd` and `tr_bit` are 0, and `subaddr` and `count_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_word` holds a validated command |
| cmd_word | input | 16 | Command word: address, T/R, subaddress, word count |
| cmd_end | input | 1 | Host signals that the current command's service is over |
| word_done | input | 1 | One data word has been transferred |
| rt_addr | input | 5 | Strapped terminal address |
| rt_addr_par | input | 1 | Odd parity bit over the strapped address |
| bcast_en | input | 1 | Allows address 31 to be treated as broadcast |
| addr_err_n | output | 1 | Low when the strap parity is wrong |
| cmd_accept | output | 1 | One-cycle pulse when a command is accepted |
| bcast | output | 1 | Captured broadcast flag |
| mode_cmd | output | 1 | Captured mode-command flag |
| tr_bit | output | 1 | Captured transmit/receive bit |
| subaddr | output | 5 | Captured subaddress field |
| count_out | output | 5 | Captured word count field, or the live word counter |
| in_cmd | output | 1 | High while a command is being serviced |

## Verification
Two pairs of events can fall in one cycle. The first is the end of one service arriving together with the next accepted command. The second is a data-word pulse landing on the edge where a new data command is accepted. The bench drives `cmd_end` with `cmd_valid`, then `word_done` with `cmd_valid` after the counter has moved off zero. It expects `in_cmd` to stay high in the first case and `count_out` to read 0 in the second. Each is judged one edge later at the ports.

// File: rtl/rt_cmd_pkg.sv
package rt_cmd_pkg;
  parameter int ADDR_W = 5;
  parameter int SA_W   = 5;
  parameter int WC_W   = 5;
  localparam int CMD_W = ADDR_W + 1 + SA_W + WC_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              tr;
    logic [SA_W-1:0]   sa;
    logic [WC_W-1:0]   wc;
  } cmd_t;

  // odd parity over strap plus parity bit
  function automatic logic strap_parity_ok(input logic [ADDR_W-1:0] a, input logic p);
    return ^{a, p};
  endfunction

  function automatic logic sa_is_mode(input logic [SA_W-1:0] sa);
    return (sa == '0) || (sa == '1);
  endfunction

  function automatic logic [WC_W-1:0] next_count(input logic [WC_W-1:0] c);
    return c + 1'b1;
  endfunction
endpackage

// File: rtl/rt_addr_match.sv
module rt_addr_match
  import rt_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              rt_addr_par,
  input  logic              bcast_en,
  output logic              par_ok,
  output logic              accept_evt,
  output logic              bcast_evt
);
  localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

  logic own_hit;
  logic bcast_hit;

  assign par_ok     = strap_parity_ok(rt_addr, rt_addr_par);
  assign own_hit    = par_ok && (cmd_addr == rt_addr);
  assign bcast_hit  = bcast_en && (cmd_addr == BCAST_ADDR);
  assign accept_evt = cmd_valid && (own_hit || bcast_hit);
  assign bcast_evt  = cmd_valid && bcast_hit;

  // R5
  parerr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !par_ok && !(bcast_en && cmd_addr == BCAST_ADDR)) |-> !accept_evt);

  // R3
  no_bcast_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bcast_en) |-> !bcast_evt);

  // R6
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_addr != rt_addr && cmd_addr != BCAST_ADDR) |-> !accept_evt);
endmodule

// File: rtl/rt_cmd_latch.sv
module rt_cmd_latch
  import rt_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_evt,
  input  logic            bcast_evt,
  input  logic            cmd_end,
  input  logic            cmd_tr,
  input  logic [SA_W-1:0] cmd_sa,
  input  logic [WC_W-1:0] cmd_wc,
  output logic            accept_q,
  output logic            in_cmd_q,
  output logic            bcast_q,
  output logic            mode_q,
  output logic            tr_q,
  output logic [SA_W-1:0] sa_q,
  output logic [WC_W-1:0] wc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_q <= 1'b0;
      in_cmd_q <= 1'b0;
      bcast_q  <= 1'b0;
      mode_q   <= 1'b0;
      tr_q     <= 1'b0;
      sa_q     <= '0;
      wc_q     <= '0;
    end else begin
      accept_q <= accept_evt;
      if (accept_evt) begin
        in_cmd_q <= 1'b1;
        bcast_q  <= bcast_evt;
        mode_q   <= sa_is_mode(cmd_sa);
        tr_q     <= cmd_tr;
        sa_q     <= cmd_sa;
        wc_q     <= cmd_wc;
      end else if (cmd_end) begin
        in_cmd_q <= 1'b0;
      end
    end
  end

  // R11
  accept_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (in_cmd_q && accept_q));

  // R11
  end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && !accept_evt) |=> !in_cmd_q);

  // R8
  mode_sa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && (cmd_sa == '0 || cmd_sa == '1)) |=> mode_q);

  // R7
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_evt |=> ($stable(sa_q) && $stable(tr_q) && $stable(wc_q)));
endmodule

// File: rtl/rt_word_count.sv
module rt_word_count
  import rt_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            word_done,
  input  logic            in_cmd,
  input  logic            mode,
  input  logic [WC_W-1:0] wc_q,
  output logic [WC_W-1:0] count_out
);
  logic [WC_W-1:0] cnt_q;
  logic            step_evt;
  logic            show_live;

  assign step_evt  = word_done && in_cmd && !mode && !clear;
  assign show_live = in_cmd && !mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (step_evt) cnt_q <= next_count(cnt_q);
  end

  assign count_out = show_live ? cnt_q : wc_q;

  // R10 and R12
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

  // R10
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (cnt_q == next_count($past(cnt_q))));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step_evt) |=> $stable(cnt_q));
endmodule

// File: rtl/rt_cmd_decoder.sv
module rt_cmd_decoder
  import rt_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              cmd_end,
  input  logic              word_done,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              rt_addr_par,
  input  logic              bcast_en,
  output logic              addr_err_n,
  output logic              cmd_accept,
  output logic              bcast,
  output logic              mode_cmd,
  output logic              tr_bit,
  output logic [SA_W-1:0]   subaddr,
  output logic [WC_W-1:0]   count_out,
  output logic              in_cmd
);
  cmd_t            cmd_f;
  logic            par_ok;
  logic            accept_evt;
  logic            bcast_evt;
  logic [WC_W-1:0] wc_q;

  assign cmd_f      = cmd_t'(cmd_word);
  assign addr_err_n = par_ok;

  rt_addr_match u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_addr    (cmd_f.addr),
    .rt_addr     (rt_addr),
    .rt_addr_par (rt_addr_par),
    .bcast_en    (bcast_en),
    .par_ok      (par_ok),
    .accept_evt  (accept_evt),
    .bcast_evt   (bcast_evt)
  );

  rt_cmd_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_evt (accept_evt),
    .bcast_evt  (bcast_evt),
    .cmd_end    (cmd_end),
    .cmd_tr     (cmd_f.tr),
    .cmd_sa     (cmd_f.sa),
    .cmd_wc     (cmd_f.wc),
    .accept_q   (cmd_accept),
    .in_cmd_q   (in_cmd),
    .bcast_q    (bcast),
    .mode_q     (mode_cmd),
    .tr_q       (tr_bit),
    .sa_q       (subaddr),
    .wc_q       (wc_q)
  );

  rt_word_count u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept_evt),
    .word_done (word_done),
    .in_cmd    (in_cmd),
    .mode      (mode_cmd),
    .wc_q      (wc_q),
    .count_out (count_out)
  );

  // R1
  accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !cmd_accept || $past(cmd_valid));

  // R9
  count_shows_wc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_cmd) |-> (count_out == wc_q));
endmodule

// File: tb/tb_rt_cmd_decoder.sv
module tb_rt_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic cmd_end = 1'b0;
  logic word_done = 1'b0;
  logic [4:0] rt_addr = '0;
  logic rt_addr_par = 1'b1;
  logic bcast_en = 1'b0;
  logic addr_err_n, cmd_accept, bcast, mode_cmd, tr_bit, in_cmd;
  logic [4:0] subaddr, count_out;

  int n_vec = 0;
  int n_bad = 0;
  logic e_tr = 1'b0, e_bc = 1'b0, e_mode = 1'b0;
  logic [4:0] e_sa = '0, e_wc = '0;

  always #4 clk = ~clk;

  rt_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_end(cmd_end), .word_done(word_done), .rt_addr(rt_addr),
    .rt_addr_par(rt_addr_par), .bcast_en(bcast_en), .addr_err_n(addr_err_n),
    .cmd_accept(cmd_accept), .bcast(bcast), .mode_cmd(mode_cmd), .tr_bit(tr_bit),
    .subaddr(subaddr), .count_out(count_out), .in_cmd(in_cmd)
  );

  // rows: strap addr, strap parity bad, bcast_en, addr, tr, sa, wc, expect accept, expect broadcast
  localparam logic [24:0] VECS [12] = '{
    {5'd5,  1'b0, 1'b1, 5'd5,  1'b1, 5'd3,  5'd4,  1'b1, 1'b0},
    {5'd5,  1'b0, 1'b0, 5'd5,  1'b0, 5'd0,  5'd2,  1'b1, 1'b0},
    {5'd5,  1'b0, 1'b1, 5'd31, 1'b0, 5'd31, 5'd18, 1'b1, 1'b1},
    {5'd5,  1'b0, 1'b0, 5'd31, 1'b1, 5'd7,  5'd1,  1'b0, 1'b0},
    {5'd31, 1'b0, 1'b0, 5'd31, 1'b1, 5'd9,  5'd0,  1'b1, 1'b0},
    {5'd31, 1'b0, 1'b1, 5'd31, 1'b0, 5'd10, 5'd3,  1'b1, 1'b1},
    {5'd5,  1'b1, 1'b1, 5'd5,  1'b0, 5'd12, 5'd6,  1'b0, 1'b0},
    {5'd5,  1'b1, 1'b1, 5'd31, 1'b1, 5'd14, 5'd11, 1'b1, 1'b1},
    {5'd5,  1'b1, 1'b0, 5'd31, 1'b0, 5'd15, 5'd13, 1'b0, 1'b0},
    {5'd6,  1'b0, 1'b1, 5'd7,  1'b1, 5'd1,  5'd9,  1'b0, 1'b0},
    {5'd31, 1'b1, 1'b0, 5'd31, 1'b0, 5'd2,  5'd21, 1'b0, 1'b0},
    {5'd0,  1'b0, 1'b1, 5'd0,  1'b1, 5'd16, 5'd0,  1'b1, 1'b0}
  };

  function automatic logic good_par(input logic [4:0] a);
    int ones = 0;
    for (int i = 0; i < 5; i++) if (a[i]) ones++;
    return (ones % 2 == 0);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic e_in, input logic [4:0] e_cnt);
    chk(in_cmd == e_in, {req, " in_cmd"}, in_cmd, e_in);
    chk(tr_bit == e_tr, {req, " R7 tr_bit"}, tr_bit, e_tr);
    chk(subaddr == e_sa, {req, " R7 subaddr"}, subaddr, e_sa);
    chk(mode_cmd == e_mode, {req, " R8 mode_cmd"}, mode_cmd, e_mode);
    chk(bcast == e_bc, {req, " bcast"}, bcast, e_bc);
    chk(count_out == e_cnt, {req, " count_out"}, count_out, e_cnt);
  endtask

  task automatic end_service();
    @(negedge clk) cmd_end = 1'b1;
    @(negedge clk) cmd_end = 1'b0;
  endtask

  task automatic pulse_word();
    @(negedge clk) word_done = 1'b1;
    @(negedge clk) word_done = 1'b0;
  endtask

  // drives a command and samples one step after the edge that takes it
  task automatic send(input logic [15:0] w, input logic also_end, input logic also_word,
                      output logic acc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w; cmd_end = also_end; word_done = also_word;
    @(posedge clk); #1;
    acc = cmd_accept;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_end = 1'b0; word_done = 1'b0;
  endtask

  task automatic note_accept(input logic [15:0] w, input logic bc);
    e_tr = w[10]; e_sa = w[9:5]; e_wc = w[4:0]; e_bc = bc;
    e_mode = (w[9:5] == 5'd0) || (w[9:5] == 5'd31);
  endtask

  initial begin
    #800000;
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic acc;
    repeat (3) @(posedge clk);
    #2;
    // R13 reset state
    check_state("R13", 1'b0, 5'd0);
    chk(cmd_accept == 1'b0, "R13 cmd_accept", cmd_accept, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      logic [24:0] v;
      logic [15:0] w;
      logic pbad, ea, eb;
      v = VECS[i];
      w = v[17:2]; pbad = v[19]; ea = v[1]; eb = v[0];
      rt_addr = v[24:20];
      rt_addr_par = good_par(v[24:20]) ^ pbad;
      bcast_en = v[18];
      end_service();
      // R4 strap parity
      chk(addr_err_n == !pbad, "R4 addr_err_n", addr_err_n, !pbad);
      send(w, 1'b0, 1'b0, acc);
      // R1 R2 R3 R5 R6 acceptance
      chk(acc == ea, $sformatf("R1/R2/R3 R5 R6 vec%0d accept", i), acc, ea);
      if (ea) note_accept(w, eb);
      check_state($sformatf("R5 R6 vec%0d", i), ea, (ea && !e_mode) ? 5'd0 : e_wc);
    end

    // R10 live counter during a data command
    rt_addr = 5'd5; rt_addr_par = good_par(5'd5); bcast_en = 1'b1;
    end_service();
    send({5'd5, 1'b0, 5'd4, 5'd7}, 1'b0, 1'b0, acc);
    note_accept({5'd5, 1'b0, 5'd4, 5'd7}, 1'b0);
    pulse_word(); pulse_word(); pulse_word();
    #1 chk(count_out == 5'd3, "R10 three words", count_out, 3);

    // R9 end of service shows the word count field
    end_service();
    #1 chk(in_cmd == 1'b0, "R11 cmd_end clears", in_cmd, 0);
    chk(count_out == 5'd7, "R9 idle shows wc", count_out, 7);
    pulse_word();
    #1 chk(count_out == 5'd7, "R9 idle word_done ignored", count_out, 7);

    // R9 mode command ignores data-word pulses
    send({5'd5, 1'b1, 5'd0, 5'd9}, 1'b0, 1'b0, acc);
    pulse_word();
    #1 chk(count_out == 5'd9, "R9 mode keeps wc", count_out, 9);

    // R11 cmd_end together with an accepted command
    send({5'd5, 1'b0, 5'd6, 5'd12}, 1'b1, 1'b0, acc);
    chk(acc == 1'b1, "R11 accept with cmd_end", acc, 1);
    #1 chk(in_cmd == 1'b1, "R11 command wins", in_cmd, 1);

    // R12 word_done together with an accepted data command
    pulse_word(); pulse_word();
    #1 chk(count_out == 5'd2, "R10 two words", count_out, 2);
    send({5'd31, 1'b1, 5'd8, 5'd5}, 1'b0, 1'b1, acc);
    #1 chk(count_out == 5'd0, "R12 counter cleared", count_out, 0);
    chk(bcast == 1'b1, "R2 broadcast flag", bcast, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule